// File: doc/BRIEF.md
# Banked Working Register File with Status Word

This block holds the working registers and the status word of a small 8-bit processor core. The storage is 32 bytes, split into four banks of eight registers. The register port takes a 3-bit index and resolves it against the bank that two status-word bits select. A second, direct port addresses the same 32 bytes by absolute address 0x00 to 0x1F. This is how plain data-memory accesses to the low address range reach the registers.

The status word lives at special-function address 0xD0. It can be read and written as a byte on the special-function port, or written one bit at a time through bit addresses 0xD0 to 0xD7. The carry, auxiliary-carry and overflow flags can also be loaded from the arithmetic unit through update inputs, each with its own enable. The parity flag is never stored. It always reflects the accumulator value presented at the `acc_i` input.

All reads are combinational. All writes take effect at the rising clock edge. Reset is synchronous and active high.

Top module: `bank_regfile_psw`

## Requirements
- R1: The register port reads combinationally the byte at address bank*8 + reg_idx, where bank is the active bank. A reg_we write stores reg_wdata there at the clock edge.
- R2: The direct port reaches the same 32 bytes at ram_addr 0x00..0x1F. When both ports write the same byte in one cycle, the register-port data is kept.
- R3: The active bank equals status bits 4:3 (bit 4 high, bit 3 low) and is shown on bank_out. A register access in the same cycle as a bank-changing write still uses the old bank. Accesses from the next cycle on use the new bank.
- R4: The status layout is bit 7 carry, bit 6 auxiliary carry, bit 5 user flag 0, bits 4:3 bank select, bit 2 overflow, bit 1 user flag 1, bit 0 parity. A special-function read at 0xD0 returns the status word, and any other address reads 0x00. A byte write at 0xD0 loads bits 7:1.
- R5: A bit write with sfr_bit_addr = 0xD0 + n (n from 0 to 7) loads sfr_bit_val into status bit n. A bit write to any other bit address changes nothing. If a byte write and a bit write to the status word happen in the same cycle, the byte write wins.
- R6: Status bit 0 always equals the XOR of all bits of acc_i, in the same cycle, and does not wait for a clock edge. Writes to bit 0, by byte or by bit, are ignored.
- R7: Each of alu_cy_en, alu_ac_en and alu_ov_en loads its flag (bits 7, 6 and 2) at the clock edge. A same-cycle software write to the status word wins over these updates.
- R8: After reset, status bits 7:1 are 0, bank 0 is active, and all 32 register bytes read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_i | input | 8 | Current accumulator value, used for parity |
| reg_we | input | 1 | Register-port write enable |
| reg_idx | input | 3 | Register index within the active bank |
| reg_wdata | input | 8 | Register-port write data |
| reg_rdata | output | 8 | Register-port read data |
| ram_we | input | 1 | Direct-port write enable |
| ram_addr | input | 5 | Direct-port absolute address |
| ram_wdata | input | 8 | Direct-port write data |
| ram_rdata | output | 8 | Direct-port read data |
| sfr_addr | input | 8 | Special-function byte address |
| sfr_we | input | 1 | Special-function byte write enable |
| sfr_wdata | input | 8 | Special-function byte write data |
| sfr_rdata | output | 8 | Special-function byte read data |
| sfr_bit_we | input | 1 | Single-bit write enable |
| sfr_bit_addr | input | 8 | Bit address |
| sfr_bit_val | input | 1 | Bit value to write |
| alu_cy_en | input | 1 | Carry update enable |
| alu_cy | input | 1 | Carry value from the arithmetic unit |
| alu_ac_en | input | 1 | Auxiliary-carry update enable |
| alu_ac | input | 1 | Auxiliary-carry value |
| alu_ov_en | input | 1 | Overflow update enable |
| alu_ov | input | 1 | Overflow value |
| psw_out | output | 8 | Full status word, including live parity |
| bank_out | output | 2 | Active bank |

## Verification
The bench builds the block with its default parameters: eight registers per bank and the status word at 0xD0. With these defaults every one of the 32 bytes and every bank is reachable from random indices and addresses. About half of the special-function and bit addresses are aimed at the status word and the rest land elsewhere. Collisions therefore occur often enough to exercise every priority: register port against direct port, byte write against bit write, and software write against flag updates.

// File: rtl/rfpsw_pkg.sv
package rfpsw_pkg;

    localparam int DATA_W = 8;
    localparam int BANK_W = 2;          // two select bits in the status word

    typedef struct packed {
        logic       cy;
        logic       ac;
        logic       f0;
        logic [1:0] rs;
        logic       ov;
        logic       f1;
        logic       p;
    } psw_t;

    typedef struct packed {
        logic cy_en;
        logic cy;
        logic ac_en;
        logic ac;
        logic ov_en;
        logic ov;
    } alu_flags_t;

    typedef struct packed {
        logic              we;
        logic [7:0]        addr;
        logic [DATA_W-1:0] wdata;
    } sfr_byte_req_t;

    typedef struct packed {
        logic       we;
        logic [7:0] addr;
        logic       val;
    } sfr_bit_req_t;

    function automatic logic odd_parity(input logic [DATA_W-1:0] v);
        return ^v;
    endfunction

endpackage

// File: rtl/rf_storage.sv
module rf_storage #(
    parameter int DEPTH  = 32,
    parameter int ADDR_W = 5,
    parameter int DW     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hi_we,
    input  logic [ADDR_W-1:0] hi_addr,
    input  logic [DW-1:0]     hi_wdata,
    input  logic              lo_we,
    input  logic [ADDR_W-1:0] lo_addr,
    input  logic [DW-1:0]     lo_wdata,
    input  logic [ADDR_W-1:0] rd_a_addr,
    output logic [DW-1:0]     rd_a_data,
    input  logic [ADDR_W-1:0] rd_b_addr,
    output logic [DW-1:0]     rd_b_data
);
    logic [DW-1:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)
                cells[g] <= '0;
            else if (hi_we && hi_addr == ADDR_W'(g))
                cells[g] <= hi_wdata;
            else if (lo_we && lo_addr == ADDR_W'(g))
                cells[g] <= lo_wdata;
        end
    end

    assign rd_a_data = cells[rd_a_addr];
    assign rd_b_data = cells[rd_b_addr];
endmodule

// File: rtl/rf_bank_map.sv
module rf_bank_map #(
    parameter int BANK_W = 2,
    parameter int IDX_W  = 3
) (
    input  logic [BANK_W-1:0]       bank,
    input  logic [IDX_W-1:0]        idx,
    output logic [BANK_W+IDX_W-1:0] addr
);
    assign addr = {bank, idx};
endmodule

// File: rtl/psw_unit.sv
module psw_unit
    import rfpsw_pkg::*;
#(
    parameter logic [7:0] PSW_ADDR = 8'hD0
) (
    input  logic              clk,
    input  logic              rst,
    input  sfr_byte_req_t     byte_req,
    input  sfr_bit_req_t      bit_req,
    input  alu_flags_t        alu,
    input  logic [DATA_W-1:0] acc,
    output psw_t              psw
);
    psw_t       held_q;
    logic [7:0] nxt;
    logic       byte_hit;
    logic       bit_hit;

    assign byte_hit = byte_req.we && (byte_req.addr == PSW_ADDR);
    assign bit_hit  = bit_req.we && (bit_req.addr[7:3] == PSW_ADDR[7:3]);

    always_comb begin
        nxt = held_q;
        if (alu.cy_en) nxt[7] = alu.cy;
        if (alu.ac_en) nxt[6] = alu.ac;
        if (alu.ov_en) nxt[2] = alu.ov;
        if (bit_hit)   nxt[bit_req.addr[2:0]] = bit_req.val;
        if (byte_hit)  nxt = byte_req.wdata;
        nxt[0] = 1'b0;                       // parity is never stored
    end

    always_ff @(posedge clk) begin
        if (rst) held_q <= '0;
        else     held_q <= psw_t'(nxt);
    end

    always_comb begin
        psw   = held_q;
        psw.p = odd_parity(acc);
    end
endmodule

// File: rtl/bank_regfile_psw.sv
module bank_regfile_psw
    import rfpsw_pkg::*;
#(
    parameter int         BANK_REGS = 8,
    parameter logic [7:0] PSW_ADDR  = 8'hD0
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [7:0]                          acc_i,
    input  logic                                reg_we,
    input  logic [$clog2(BANK_REGS)-1:0]        reg_idx,
    input  logic [7:0]                          reg_wdata,
    output logic [7:0]                          reg_rdata,
    input  logic                                ram_we,
    input  logic [2+$clog2(BANK_REGS)-1:0]      ram_addr,
    input  logic [7:0]                          ram_wdata,
    output logic [7:0]                          ram_rdata,
    input  logic [7:0]                          sfr_addr,
    input  logic                                sfr_we,
    input  logic [7:0]                          sfr_wdata,
    output logic [7:0]                          sfr_rdata,
    input  logic                                sfr_bit_we,
    input  logic [7:0]                          sfr_bit_addr,
    input  logic                                sfr_bit_val,
    input  logic                                alu_cy_en,
    input  logic                                alu_cy,
    input  logic                                alu_ac_en,
    input  logic                                alu_ac,
    input  logic                                alu_ov_en,
    input  logic                                alu_ov,
    output logic [7:0]                          psw_out,
    output logic [1:0]                          bank_out
);
    localparam int IDX_W  = $clog2(BANK_REGS);
    localparam int ADDR_W = BANK_W + IDX_W;
    localparam int DEPTH  = (1 << BANK_W) * BANK_REGS;

    psw_t              psw;
    sfr_byte_req_t     byte_req;
    sfr_bit_req_t      bit_req;
    alu_flags_t        alu;
    logic [ADDR_W-1:0] reg_addr;

    assign byte_req = '{we: sfr_we, addr: sfr_addr, wdata: sfr_wdata};
    assign bit_req  = '{we: sfr_bit_we, addr: sfr_bit_addr, val: sfr_bit_val};
    assign alu      = '{cy_en: alu_cy_en, cy: alu_cy, ac_en: alu_ac_en,
                        ac: alu_ac, ov_en: alu_ov_en, ov: alu_ov};

    psw_unit #(.PSW_ADDR(PSW_ADDR)) u_psw (
        .clk      (clk),
        .rst      (rst),
        .byte_req (byte_req),
        .bit_req  (bit_req),
        .alu      (alu),
        .acc      (acc_i),
        .psw      (psw)
    );

    rf_bank_map #(.BANK_W(BANK_W), .IDX_W(IDX_W)) u_map (
        .bank (psw.rs),
        .idx  (reg_idx),
        .addr (reg_addr)
    );

    rf_storage #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DW(DATA_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .hi_we     (reg_we),
        .hi_addr   (reg_addr),
        .hi_wdata  (reg_wdata),
        .lo_we     (ram_we),
        .lo_addr   (ram_addr),
        .lo_wdata  (ram_wdata),
        .rd_a_addr (reg_addr),
        .rd_a_data (reg_rdata),
        .rd_b_addr (ram_addr),
        .rd_b_data (ram_rdata)
    );

    assign psw_out   = psw;
    assign bank_out  = psw.rs;
    assign sfr_rdata = (sfr_addr == PSW_ADDR) ? psw : 8'h00;
endmodule

// File: rtl/rfpsw_checker.sv
module rfpsw_checker #(
    parameter int         ADDR_W   = 5,
    parameter int         IDX_W    = 3,
    parameter logic [7:0] PSW_ADDR = 8'hD0
) (
    input logic              clk,
    input logic              rst,
    input logic [7:0]        acc_i,
    input logic [7:0]        psw_out,
    input logic [1:0]        bank_out,
    input logic              sfr_we,
    input logic [7:0]        sfr_addr,
    input logic [7:0]        sfr_wdata,
    input logic              sfr_bit_we,
    input logic [7:0]        sfr_bit_addr,
    input logic              alu_cy_en,
    input logic              alu_cy,
    input logic              alu_ac_en,
    input logic              alu_ov_en,
    input logic              reg_we,
    input logic [IDX_W-1:0]  reg_idx,
    input logic [7:0]        reg_wdata,
    input logic [ADDR_W-1:0] ram_addr,
    input logic [7:0]        ram_rdata
);
    logic byte_hit;
    logic bit_hit;
    assign byte_hit = sfr_we && sfr_addr == PSW_ADDR;
    assign bit_hit  = sfr_bit_we && sfr_bit_addr[7:3] == PSW_ADDR[7:3];

    assert_reset_state_R8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (psw_out[7:1] == 7'd0 && bank_out == 2'd0));

    assert_parity_live_R6: assert property (@(posedge clk) disable iff (rst)
        psw_out[0] == ^acc_i);

    assert_byte_write_R4: assert property (@(posedge clk) disable iff (rst)
        byte_hit |=> ({psw_out[7:1], 1'b0} == ($past(sfr_wdata) & 8'hFE)));

    assert_carry_update_R7: assert property (@(posedge clk) disable iff (rst)
        (alu_cy_en && !byte_hit && !(bit_hit && sfr_bit_addr[2:0] == 3'd7))
        |=> psw_out[7] == $past(alu_cy));

    assert_foreign_bit_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        (sfr_bit_we && !bit_hit && !sfr_we && !alu_cy_en && !alu_ac_en && !alu_ov_en)
        |=> $stable(psw_out[7:1]));

    assert_reg_write_visible_R2: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> (ram_addr != $past({bank_out, reg_idx}) || ram_rdata == $past(reg_wdata)));
endmodule

bind bank_regfile_psw rfpsw_checker #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .PSW_ADDR(PSW_ADDR)
) u_rfpsw_checker (
    .clk(clk), .rst(rst), .acc_i(acc_i), .psw_out(psw_out), .bank_out(bank_out),
    .sfr_we(sfr_we), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_bit_we(sfr_bit_we), .sfr_bit_addr(sfr_bit_addr),
    .alu_cy_en(alu_cy_en), .alu_cy(alu_cy), .alu_ac_en(alu_ac_en), .alu_ov_en(alu_ov_en),
    .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .ram_addr(ram_addr), .ram_rdata(ram_rdata)
);

// File: tb/test_bank_regfile_psw.sv
`timescale 1ns/1ps
module test_bank_regfile_psw;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] acc_i = '0;
    logic       reg_we = 0;
    logic [2:0] reg_idx = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       ram_we = 0;
    logic [4:0] ram_addr = '0;
    logic [7:0] ram_wdata = '0;
    logic [7:0] ram_rdata;
    logic [7:0] sfr_addr = '0;
    logic       sfr_we = 0;
    logic [7:0] sfr_wdata = '0;
    logic [7:0] sfr_rdata;
    logic       sfr_bit_we = 0;
    logic [7:0] sfr_bit_addr = '0;
    logic       sfr_bit_val = 0;
    logic       alu_cy_en = 0, alu_cy = 0, alu_ac_en = 0, alu_ac = 0, alu_ov_en = 0, alu_ov = 0;
    logic [7:0] psw_out;
    logic [1:0] bank_out;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] m_mem [32];
    logic [7:0] m_psw;          // bit 0 unused in the model

    always #4 clk = ~clk;       // 125 MHz

    bank_regfile_psw i_bank_regfile_psw (.*);

    function automatic logic [7:0] exp_psw();
        return {m_psw[7:1], ^acc_i};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle();
        reg_we = 0; ram_we = 0; sfr_we = 0; sfr_bit_we = 0;
        alu_cy_en = 0; alu_ac_en = 0; alu_ov_en = 0;
    endtask

    task automatic check_ports();
        chk("R1 reg read", reg_rdata, m_mem[{m_psw[4:3], reg_idx}]);
        chk("R2 ram read", ram_rdata, m_mem[ram_addr]);
        chk("R4 sfr read", sfr_rdata, (sfr_addr == 8'hD0) ? exp_psw() : 8'h00);
        chk("R6 psw", psw_out, exp_psw());
        chk("R3 bank", {6'd0, bank_out}, {6'd0, m_psw[4:3]});
    endtask

    // one clock: update model from the driven inputs, then settle at the falling edge
    task automatic tick();
        logic [7:0] np;
        logic [4:0] ra;
        @(posedge clk);
        np = m_psw;
        if (alu_cy_en) np[7] = alu_cy;
        if (alu_ac_en) np[6] = alu_ac;
        if (alu_ov_en) np[2] = alu_ov;
        if (sfr_bit_we && sfr_bit_addr[7:3] == 5'h1A) np[sfr_bit_addr[2:0]] = sfr_bit_val;
        if (sfr_we && sfr_addr == 8'hD0) np = sfr_wdata;
        np[0] = 1'b0;
        ra = {m_psw[4:3], reg_idx};
        if (ram_we) m_mem[ram_addr] = ram_wdata;
        if (reg_we) m_mem[ra] = reg_wdata;
        m_psw = np;
        @(negedge clk);
        #1;
    endtask

    task automatic sfr_write(input logic [7:0] v);
        sfr_addr = 8'hD0; sfr_we = 1; sfr_wdata = v;
    endtask

    initial begin
        #(8 * 190000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        foreach (m_mem[i]) m_mem[i] = 8'h00;
        m_psw = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0; #1;

        // R8: reset state
        chk("R8 psw after reset", psw_out, 8'h00);
        chk("R8 bank after reset", {6'd0, bank_out}, 8'h00);
        for (int a = 0; a < 32; a++) begin
            ram_addr = 5'(a); #1;
            chk("R8 ram cleared", ram_rdata, 8'h00);
        end

        // R3 + R1: select bank 2, write R5, read it back through both ports
        @(negedge clk); sfr_write(8'h10); tick(); idle();
        chk("R3 bank 2 selected", {6'd0, bank_out}, 8'h02);
        reg_idx = 3'd5; reg_we = 1; reg_wdata = 8'hA5; tick(); idle();
        ram_addr = 5'h15; #1;
        chk("R2 direct sees banked write", ram_rdata, 8'hA5);
        chk("R1 reg read back", reg_rdata, 8'hA5);

        // R3: register write in the cycle of a bank change uses the old bank
        @(negedge clk); sfr_write(8'h08); reg_idx = 3'd0; reg_we = 1; reg_wdata = 8'h3C; tick(); idle();
        ram_addr = 5'h10; #1; chk("R3 old bank written", ram_rdata, 8'h3C);
        ram_addr = 5'h08; #1; chk("R3 new bank untouched", ram_rdata, 8'h00);
        chk("R3 bank 1 active", {6'd0, bank_out}, 8'h01);

        // R2: same-byte collision, register port wins
        @(negedge clk); reg_idx = 3'd1; reg_we = 1; reg_wdata = 8'h11;
        ram_addr = 5'h09; ram_we = 1; ram_wdata = 8'h22; tick(); idle();
        chk("R2 collision reg wins", ram_rdata, 8'h11);

        // R6: parity is live and not writable
        acc_i = 8'h07; #1; chk("R6 parity odd", {7'd0, psw_out[0]}, 8'h01);
        acc_i = 8'h00; sfr_write(8'h09); tick(); idle();
        chk("R6 byte write to parity ignored", {7'd0, psw_out[0]}, 8'h00);
        sfr_bit_we = 1; sfr_bit_addr = 8'hD0; sfr_bit_val = 1; tick(); idle();
        chk("R6 bit write to parity ignored", {7'd0, psw_out[0]}, 8'h00);

        // R7: software wins over carry update; lone overflow update lands
        alu_cy_en = 1; alu_cy = 0; sfr_write(8'h88); tick(); idle();
        chk("R7 software over carry", psw_out, 8'h88);
        alu_ov_en = 1; alu_ov = 1; tick(); idle();
        chk("R7 overflow update", psw_out, 8'h8C);

        // R5: bit writes, foreign bit address, byte beats bit
        sfr_bit_we = 1; sfr_bit_addr = 8'hD6; sfr_bit_val = 1; tick(); idle();
        chk("R5 bit 6 set", psw_out, 8'hCC);
        sfr_bit_we = 1; sfr_bit_addr = 8'hE7; sfr_bit_val = 0; tick(); idle();
        chk("R5 foreign bit ignored", psw_out, 8'hCC);
        sfr_write(8'h00); sfr_bit_we = 1; sfr_bit_addr = 8'hD5; sfr_bit_val = 1; tick(); idle();
        chk("R5 byte beats bit", psw_out, 8'h00);

        // R4: other address reads zero
        sfr_addr = 8'hE0; #1; chk("R4 other sfr reads zero", sfr_rdata, 8'h00);

        // random mix
        for (int it = 0; it < 3000; it++) begin
            acc_i        = 8'($urandom);
            reg_idx      = 3'($urandom);
            reg_wdata    = 8'($urandom);
            reg_we       = ($urandom % 4) == 0;
            ram_addr     = 5'($urandom);
            ram_wdata    = 8'($urandom);
            ram_we       = ($urandom % 4) == 0;
            sfr_addr     = ($urandom % 2) ? 8'hD0 : 8'($urandom);
            sfr_wdata    = 8'($urandom);
            sfr_we       = ($urandom % 8) == 0;
            sfr_bit_addr = ($urandom % 2) ? (8'hD0 | 8'($urandom % 8)) : 8'($urandom);
            sfr_bit_val  = 1'($urandom);
            sfr_bit_we   = ($urandom % 6) == 0;
            {alu_cy_en, alu_ac_en, alu_ov_en, alu_cy, alu_ac, alu_ov} = 6'($urandom);
            #1;
            check_ports();
            tick();
        end
        idle();
        check_ports();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule